// File: doc/BRIEF.md
# Clause 22 MDIO Management Frame Master

This block drives the two-wire management bus of an Ethernet PHY. The host hands it one packed 32-bit command word that carries the operation, the PHY address, the register number and sixteen bits of write data. Once that word is accepted, the block produces a management clock and shifts out a complete Clause 22 frame. For a read it releases the data line at turnaround and captures the sixteen bits the PHY returns. Those bits land in place in the low half of the same command word, where the host reads them back.

An idle flag tells the host when a new command may be written. Words written while the flag is low are dropped. A port-enable input holds back the start of a frame, and a two-bit divider code selects how many host clocks make up one management clock period. The data line is presented as a separate output value, output enable and input, so that the tri-state pad sits outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A written word launches a frame only if bit 30 and bit 17 are both 1 and exactly one of bit 29 (read) and bit 28 (write) is 1. Any other word is stored and read back unchanged, no frame starts and the idle flag stays high.
- R2: A frame is 64 MDC periods long. It sends 32 ones, then start bits 0,1, then the opcode (1,0 for a read, 0,1 for a write). Next come the PHY address from word bits 27:23 and the register number from bits 22:18, then the turnaround and sixteen data bits, every field MSB first.
- R3: In a read frame, mdio_oe is low from the first turnaround bit (the 47th frame bit) to the end of the frame. mdio_i is sampled on each rising MDC edge of the sixteen data bits. At frame end the captured value replaces word bits 15:0, and bits 31:16 are kept.
- R4: In a write frame, mdio_oe is high for all 64 bits, the turnaround is sent as 1,0, and the data field is word bits 15:0. The stored word is not changed by the frame.
- R5: mgmt_idle is low from the clock after an accepted command until the frame ends. With the port enabled, it is high again exactly 64 x divisor + 1 clocks after the accepting edge.
- R6: A write of the command word while mgmt_idle is low is ignored: the stored word is unchanged and no extra frame is sent.
- R7: While port_en is low, no frame starts and MDC stays low. An accepted command waits with mgmt_idle low, and it starts once port_en is set.
- R8: div_code selects the MDC period in host clocks: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 48. MDC is low for the first half of each period and high for the second. MDC is low whenever no frame runs.
- R9: After reset, the word reads 0, mgmt_idle is 1, and MDC and mdio_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable; gates frame start |
| div_code | input | 2 | MDC divider selection, latched at frame start |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word, with read data in bits 15:0 |
| mgmt_idle | output | 1 | High when a new command is accepted |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the pad |

## Verification
A wrong bit counter or a shift register loaded in the wrong order shows up in the serial stream on the first field after the preamble, and a bus watcher sampling at rising MDC catches it within 64 MDC periods. A wrong divider count shows up one MDC period after the start as a rising-edge spacing that does not match. A busy flag that is left set or cleared too early shows up in the exact cycle count of the idle flag. A lost or stray write shows up in the command word read back right after the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int CMD_MARK_HI = 30;
  localparam int CMD_MARK_LO = 17;
  localparam int CMD_RD      = 29;
  localparam int CMD_WR      = 28;
  localparam int PHY_LSB     = 23;
  localparam int REG_LSB     = 18;

  typedef struct packed {
    logic        valid;
    logic        is_read;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t decode_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.valid   = w[CMD_MARK_HI] & w[CMD_MARK_LO] & (w[CMD_RD] ^ w[CMD_WR]);
    c.is_read = w[CMD_RD];
    c.phy     = w[PHY_LSB +: 5];
    c.regn    = w[REG_LSB +: 5];
    c.data    = w[15:0];
    return c;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             end_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = (half << 1) - ONE;
  assign rise_evt = run && !restart && (cnt_q == half - ONE);
  assign end_evt  = run && !restart && (cnt_q == last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (restart || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (end_evt) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = cnt_q + ONE;
      if (rise_evt) mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R8: clock is quiet whenever no frame runs
  assert_mdc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R8: every period ends with the clock low
  assert_mdc_period_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_evt,
  input  logic        end_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      sh_q, sh_d;
  logic [15:0]      rdat_q, rdat_d;
  logic             cap_en;
  logic [31:0]      load_word;

  assign load_word = {2'b01, (cmd.is_read ? 2'b10 : 2'b01), cmd.phy, cmd.regn,
                      2'b10, cmd.data};
  assign cap_en    = busy_q && rd_q && rise_evt && (idx_q >= DAT_IDX);
  assign done      = busy_q && end_evt && (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rdat_d = rdat_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = cmd.is_read;
      idx_d  = '0;
      sh_d   = load_word;
    end else if (busy_q) begin
      if (cap_en) rdat_d = {rdat_q[14:0], mdio_i};
      if (end_evt) begin
        if (idx_q == LAST_IDX) busy_d = 1'b0;
        else                   idx_d  = idx_q + 1'b1;
        if (idx_q >= PRE_IDX)  sh_d   = {sh_q[30:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rdat_q <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rdat_q <= rdat_d;
    end
  end

  assign busy    = busy_q;
  assign rdata   = rdat_q;
  assign mdio_o  = (idx_q < PRE_IDX) ? 1'b1 : sh_q[31];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= TA_IDX));

  // R3: the PHY is only sampled while the block has released the line
  assert_capture_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !mdio_oe);
  // R2: every frame begins at its first preamble bit
  assert_frame_begin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idx_q == '0) && mdio_o);
  // R5: frame end drops busy on the next cycle
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_TABLE [4] = '{8, 16, 32, 48}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic [1:0]  div_code,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mgmt_idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  function automatic int unsigned max_div();
    int unsigned m = 2;
    for (int i = 0; i < 4; i++) if (DIV_TABLE[i] > m) m = DIV_TABLE[i];
    return m;
  endfunction

  localparam int unsigned MAX_DIV = max_div();
  localparam int CNT_W = $clog2(MAX_DIV);

  logic [31:0]      word_q, word_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] half_sel;
  logic             seq_busy, seq_done, launch;
  logic             rise_evt, end_evt;
  logic [15:0]      seq_rdata;
  mgmt_cmd_t        cmd_now;
  mgmt_cmd_t        wr_cmd;

  assign cmd_now   = decode_cmd(word_q);
  assign wr_cmd    = decode_cmd(cmd_wdata);
  assign mgmt_idle = !pend_q && !seq_busy;
  assign launch    = pend_q && port_en && !seq_busy;

  always_comb begin
    half_sel = '0;
    for (int i = 0; i < 4; i++)
      if (div_code == 2'(i)) half_sel = CNT_W'(DIV_TABLE[i] / 2);
  end

  always_comb begin
    word_d = word_q;
    pend_d = pend_q;
    half_d = half_q;
    if (cmd_wr && mgmt_idle) begin
      word_d = cmd_wdata;
      pend_d = wr_cmd.valid;
    end
    if (launch) begin
      pend_d = 1'b0;
      half_d = half_sel;
    end
    if (seq_done && cmd_now.is_read) word_d[15:0] = seq_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= 1'b0;
      half_q <= CNT_W'(DIV_TABLE[0] / 2);
    end else begin
      word_q <= word_d;
      pend_q <= pend_d;
      half_q <= half_d;
    end
  end

  mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (seq_busy),
    .restart  (launch),
    .half     (half_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .end_evt  (end_evt)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .cmd      (cmd_now),
    .rise_evt (rise_evt),
    .end_evt  (end_evt),
    .mdio_i   (mdio_i),
    .busy     (seq_busy),
    .done     (seq_done),
    .rdata    (seq_rdata),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  assign cmd_rdata = word_q;

  // R6: a write during a transaction leaves the word alone
  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !mgmt_idle && !seq_done) |=> $stable(word_q));
  // R7: no frame begins while the port is disabled
  assert_enable_gates_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !port_en) |=> !seq_busy);
  // R1: only a well-formed command leaves a request pending
  assert_pending_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> cmd_now.valid);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  div_code = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mgmt_idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  logic [63:0] cap;
  int          rises = 0;
  int          oe_rises = 0;
  time         rise_t [0:3];
  logic [15:0] phy_resp = '0;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_code(div_code),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .mgmt_idle(mgmt_idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY-side observer and responder
  always @(posedge mdc) begin
    if (rises < 64) cap[63 - rises] = mdio_oe ? mdio_o : mdio_i;
    if (mdio_oe) oe_rises++;
    if (rises < 4) rise_t[rises] = $time;
    rises++;
    #1;
    if (rises == 47)      mdio_i = 1'b0;
    else if (rises >= 48 && rises < 64) mdio_i = phy_resp[63 - rises];
    else                  mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(bit rd, logic [4:0] phy, logic [4:0] rg,
                                          logic [15:0] d);
    return (32'd1 << 30) | (32'd1 << 17) | (rd ? (32'd1 << 29) : (32'd1 << 28)) |
           ({27'd0, phy} << 23) | ({27'd0, rg} << 18) | {16'd0, d};
  endfunction

  function automatic logic [63:0] mk_frame(bit rd, logic [4:0] phy, logic [4:0] rg,
                                           logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  function automatic int div_of(logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 48;
    endcase
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    rises = 0; oe_rises = 0; cap = '0;
    cmd_wdata = w; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    while (!mgmt_idle && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(cmd_rdata == 32'd0, "R9 word", cmd_rdata, 0);
    chk(mgmt_idle && !mdc && !mdio_oe, "R9 idle/mdc/oe",
        {mgmt_idle, mdc, mdio_oe}, 3'b100);
  endtask

  task automatic t_write(input logic [1:0] code, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] w;
    int n;
    w = mk_word(0, phy, rg, d);
    div_code = code;
    issue(w);
    chk(!mgmt_idle, "R5 idle low after accept", mgmt_idle, 0);
    wait_idle(n);
    chk(n == 64 * div_of(code) + 2, "R5 frame length", n, 64 * div_of(code) + 2);
    chk(cap == mk_frame(0, phy, rg, d), "R2 write frame", cap, mk_frame(0, phy, rg, d));
    chk(oe_rises == 64, "R4 oe held", oe_rises, 64);
    chk(cmd_rdata == w, "R4 word kept", cmd_rdata, w);
    chk(rise_t[2] - rise_t[1] == 20 * div_of(code), "R8 period",
        rise_t[2] - rise_t[1], 20 * div_of(code));
    chk(!mdc, "R8 mdc low idle", mdc, 0);
  endtask

  task automatic t_read(input logic [1:0] code, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] resp);
    logic [31:0] w;
    int n;
    w = mk_word(1, phy, rg, 16'hDEAD);
    phy_resp = resp;
    div_code = code;
    issue(w);
    wait_idle(n);
    chk(cap == mk_frame(1, phy, rg, resp), "R2 read frame", cap, mk_frame(1, phy, rg, resp));
    chk(oe_rises == 46, "R3 release at turnaround", oe_rises, 46);
    chk(cmd_rdata == {w[31:16], resp}, "R3 read data in place", cmd_rdata, {w[31:16], resp});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] w;
    int n;
    w = mk_word(1, 5'd3, 5'd1, 16'h0000);
    phy_resp = 16'h7949;
    div_code = 2'd0;
    issue(w);
    repeat (40) @(negedge clk);
    cmd_wdata = mk_word(0, 5'd9, 5'd9, 16'h1111); cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    wait_idle(n);
    chk(cmd_rdata == {w[31:16], 16'h7949}, "R6 busy write dropped", cmd_rdata,
        {w[31:16], 16'h7949});
    repeat (200) @(negedge clk);
    chk(rises == 64 && mgmt_idle, "R6 no extra frame", rises, 64);
  endtask

  task automatic t_invalid(input logic [31:0] w, input string tag);
    issue(w);
    chk(mgmt_idle, {"R1 idle stays ", tag}, mgmt_idle, 1);
    repeat (150) @(negedge clk);
    chk(rises == 0 && cmd_rdata == w, {"R1 no frame ", tag}, cmd_rdata, w);
  endtask

  task automatic t_enable_gate();
    int n;
    port_en = 1'b0;
    div_code = 2'd0;
    issue(mk_word(0, 5'd1, 5'd4, 16'h00F0));
    repeat (300) @(negedge clk);
    chk(!mgmt_idle && rises == 0 && !mdc, "R7 held while disabled", rises, 0);
    port_en = 1'b1;
    wait_idle(n);
    chk(cap == mk_frame(0, 5'd1, 5'd4, 16'h00F0), "R7 starts once enabled", cap,
        mk_frame(0, 5'd1, 5'd4, 16'h00F0));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    port_en = 1'b1;
    t_write(2'd0, 5'h15, 5'h0A, 16'hA5C3);
    t_write(2'd2, 5'h01, 5'h1F, 16'h8001);
    t_write(2'd3, 5'h1E, 5'h00, 16'h3C5A);
    t_write(2'd1, 5'h00, 5'h11, 16'hFFFF);
    t_read(2'd0, 5'h07, 5'h01, 16'h796D);
    t_read(2'd1, 5'h1F, 5'h02, 16'h0141);
    t_busy_ignore();
    t_invalid(mk_word(0, 5'd2, 5'd2, 16'h1234) & ~(32'd1 << 17), "bit17 clear");
    t_invalid(mk_word(0, 5'd2, 5'd2, 16'h1234) | (32'd1 << 29), "both ops");
    t_invalid(mk_word(1, 5'd2, 5'd2, 16'h1234) & ~(32'd1 << 30), "bit30 clear");
    t_enable_gate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule